// File: doc/BRIEF.md
# Predicated Issue Gate with Condition Flags

This block sits in the execute stage of a 32-bit pipeline and decides, for each instruction presented to it, whether that instruction may take effect or must be squashed into a no-operation. The decision compares the four most significant bits of the instruction, its predicate, against four status flags: negative, zero, carry and signed overflow. The block also holds those flags. It reloads them from the ALU result flags, but only for an instruction that is valid, passes its predicate and asks for a flag update.

The decision is combinational and is based on the flag register as it stands at the start of the cycle. A flag update requested by the current instruction is written at the next clock edge, so the following instruction sees it. Predicate 1111 is reserved: an instruction that carries it never executes, and a dedicated output reports it.

Top module: `cond_gate_unit`

## Requirements
- R1: After reset, `flagsOut` is 4'b0000. The bit order is bit 3 = N (negative), bit 2 = Z (zero), bit 1 = C (carry), bit 0 = V (overflow).
- R2: The predicate is `instrWord[31:28]`. While `instrValid` is high, `execEn` follows the predicate in the same cycle, with no clock edge between them.
- R3: The single-flag predicates are 0000 (Z set), 0001 (Z clear), 0010 (C set), 0011 (C clear), 0100 (N set), 0101 (N clear), 0110 (V set) and 0111 (V clear).
- R4: Predicate 1000 holds when C is set and Z is clear. Predicate 1001 holds when C is clear or Z is set.
- R5: Predicate 1010 holds when N equals V, and 1011 when N differs from V. Predicate 1100 holds when Z is clear and N equals V, and 1101 when Z is set or N differs from V.
- R6: Predicate 1110 makes `execEn` high whatever the flags are.
- R7: Predicate 1111 never executes. While `instrValid` is high, it drives `reservedCond` high.
- R8: While `instrValid` is low, `execEn` and `reservedCond` are low and the flags do not change.
- R9: A valid instruction that passes its predicate with `setFlags` high loads `aluFlags` into `flagsOut` at the next rising clock edge.
- R10: The flags hold their value when `setFlags` is low, or when the instruction fails its predicate, even if `setFlags` is high.
- R11: Each instruction is judged by the flags from before its own update. The update it makes applies to the instruction in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| instrWord | input | 32 | Instruction word; the top four bits are the predicate |
| instrValid | input | 1 | Qualifies `instrWord` for this cycle |
| setFlags | input | 1 | Instruction requests a flag update |
| aluFlags | input | 4 | ALU result flags {N,Z,C,V} |
| execEn | output | 1 | Instruction executes (predicate passed) |
| reservedCond | output | 1 | Valid instruction carries predicate 1111 |
| flagsOut | output | 4 | Current flag register {N,Z,C,V} |

## Verification
The hardest case to reach from the ports is a predicate evaluated against one exact flag combination, because the flags can only be loaded by an instruction that itself passes its predicate. For each of the 16 flag values, the bench first issues an always-execute instruction with `setFlags` high to preload that value. It then sweeps all 16 predicates against it, with `setFlags` low so the flags stay put. Back-to-back instructions, one updating the flags and the next consuming them, expose any forwarding of a same-cycle update into the decision.

// File: rtl/cgu_pkg.sv
package cgu_pkg;
  localparam int FLAG_W = 4;
  localparam int COND_W = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [COND_W-1:0] {
    PredZSet    = 4'b0000,
    PredZClr    = 4'b0001,
    PredCSet    = 4'b0010,
    PredCClr    = 4'b0011,
    PredNSet    = 4'b0100,
    PredNClr    = 4'b0101,
    PredVSet    = 4'b0110,
    PredVClr    = 4'b0111,
    PredUHigher = 4'b1000,
    PredULowSm  = 4'b1001,
    PredSGe     = 4'b1010,
    PredSLt     = 4'b1011,
    PredSGt     = 4'b1100,
    PredSLe     = 4'b1101,
    PredAlways  = 4'b1110,
    PredReserve = 4'b1111
  } pred_e;

  typedef struct packed {
    logic execEn;
    logic flagWe;
    logic reservedHit;
  } gate_strobe_t;
endpackage

// File: rtl/cgu_ctrl.sv
module cgu_ctrl
  import cgu_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [COND_W-1:0]   predCode,
  input  logic                instrValid,
  input  logic                setFlags,
  input  flags_t              curFlags,
  output gate_strobe_t        strobes
);
  logic  predHolds;
  pred_e predSel;

  assign predSel = pred_e'(predCode);

  always_comb begin
    unique case (predSel)
      PredZSet:    predHolds = curFlags.z;
      PredZClr:    predHolds = !curFlags.z;
      PredCSet:    predHolds = curFlags.c;
      PredCClr:    predHolds = !curFlags.c;
      PredNSet:    predHolds = curFlags.n;
      PredNClr:    predHolds = !curFlags.n;
      PredVSet:    predHolds = curFlags.v;
      PredVClr:    predHolds = !curFlags.v;
      PredUHigher: predHolds = curFlags.c && !curFlags.z;
      PredULowSm:  predHolds = !curFlags.c || curFlags.z;
      PredSGe:     predHolds = (curFlags.n == curFlags.v);
      PredSLt:     predHolds = (curFlags.n != curFlags.v);
      PredSGt:     predHolds = !curFlags.z && (curFlags.n == curFlags.v);
      PredSLe:     predHolds = curFlags.z || (curFlags.n != curFlags.v);
      PredAlways:  predHolds = 1'b1;
      PredReserve: predHolds = 1'b0;
      default:     predHolds = 1'b0;
    endcase
  end

  always_comb begin
    strobes.execEn      = instrValid && predHolds;
    strobes.flagWe      = instrValid && predHolds && setFlags;
    strobes.reservedHit = instrValid && (predSel == PredReserve);
  end

  // R8
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |-> !strobes.execEn && !strobes.reservedHit);
  // R7
  reserved_never_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reservedHit |-> !strobes.execEn);
  // R6
  always_exec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && predCode == 4'b1110) |-> strobes.execEn);
  // R10
  write_needs_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flagWe |-> strobes.execEn && setFlags);
endmodule

// File: rtl/cgu_flagpath.sv
module cgu_flagpath
  import cgu_pkg::*;
#(
  parameter logic [FLAG_W-1:0] RESET_FLAGS = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  gate_strobe_t strobes,
  input  flags_t       aluFlags,
  output flags_t       flagsQ
);
  logic [FLAG_W-1:0] flagBits;
  logic [FLAG_W-1:0] aluBits;

  assign aluBits = aluFlags;

  for (genvar b = 0; b < FLAG_W; b++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               flagBits[b] <= RESET_FLAGS[b];
      else if (strobes.flagWe) flagBits[b] <= aluBits[b];
    end
  end

  assign flagsQ = flags_t'(flagBits);

  // R9
  flag_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flagWe |=> flagsQ == $past(aluFlags));
  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.flagWe |=> $stable(flagsQ));
endmodule

// File: rtl/cond_gate_unit.sv
module cond_gate_unit
  import cgu_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               instrValid,
  input  logic               setFlags,
  input  logic [FLAG_W-1:0]  aluFlags,
  output logic               execEn,
  output logic               reservedCond,
  output logic [FLAG_W-1:0]  flagsOut
);
  localparam int PRED_LSB = INSTR_W - COND_W;

  gate_strobe_t strobes;
  flags_t       flagsQ;
  logic         unusedLow;

  assign unusedLow = ^instrWord[PRED_LSB-1:0];

  cgu_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .predCode   (instrWord[INSTR_W-1:PRED_LSB]),
    .instrValid (instrValid),
    .setFlags   (setFlags),
    .curFlags   (flagsQ),
    .strobes    (strobes)
  );

  cgu_flagpath u_flags (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .aluFlags (flags_t'(aluFlags)),
    .flagsQ   (flagsQ)
  );

  assign execEn       = strobes.execEn;
  assign reservedCond = strobes.reservedHit;
  assign flagsOut     = flagsQ;
endmodule

// File: tb/cond_gate_unit_tb.sv
module cond_gate_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instrWord = '0;
  logic        instrValid = 1'b0;
  logic        setFlags = 1'b0;
  logic [3:0]  aluFlags = '0;
  logic        execEn, reservedCond;
  logic [3:0]  flagsOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_gate_unit dut_i (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .instrValid(instrValid),
    .setFlags(setFlags), .aluFlags(aluFlags), .execEn(execEn),
    .reservedCond(reservedCond), .flagsOut(flagsOut)
  );

  // Expected predicate outcome; flags are {N,Z,C,V}.
  function automatic bit expectPass(input logic [3:0] p, input logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (p)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one instruction at a falling edge; check the combinational outputs.
  task automatic issue(input logic [3:0] p, input bit vld, input bit sf,
                       input logic [3:0] alu, input string req,
                       input bit expExec, input bit expRes);
    @(negedge clk);
    instrWord  = {p, 28'h5A5A5A5};
    instrValid = vld;
    setFlags   = sf;
    aluFlags   = alu;
    #2;
    check(req, execEn, expExec);
    check(req, reservedCond, expRes);
  endtask

  task automatic idle();
    @(negedge clk);
    instrValid = 0; setFlags = 0;
  endtask

  task automatic loadFlags(input logic [3:0] f);
    issue(4'hE, 1, 1, f, "R6", 1, 0);
    idle();
    check("R9 load", flagsOut, f);
  endtask

  task automatic testReset();
    check("R1 flags", flagsOut, 4'h0);
    check("R1 exec", execEn, 0);
  endtask

  task automatic testAllPredicates();
    for (int f = 0; f < 16; f++) begin
      loadFlags(f[3:0]);
      for (int p = 0; p < 16; p++) begin
        // R3 R4 R5 R6 R7 via the expectation model; R2 same-cycle decision
        issue(p[3:0], 1, 0, ~f[3:0], (p < 8) ? "R3" : (p < 10) ? "R4" : (p < 14) ? "R5" : (p == 14) ? "R6" : "R7",
              expectPass(p[3:0], f[3:0]), p == 15);
      end
      idle();
      check("R10 sf low", flagsOut, f[3:0]);
    end
  endtask

  task automatic testInvalid();
    loadFlags(4'b0100);
    issue(4'hE, 0, 1, 4'b1011, "R8", 0, 0);
    issue(4'hF, 0, 0, 4'b1011, "R8", 0, 0);
    idle();
    check("R8 flags", flagsOut, 4'b0100);
  endtask

  task automatic testSquashNoUpdate();
    loadFlags(4'b0000);
    issue(4'h0, 1, 1, 4'b1111, "R10", 0, 0);
    issue(4'hF, 1, 1, 4'b1111, "R7", 0, 1);
    idle();
    check("R10 squash", flagsOut, 4'b0000);
  endtask

  task automatic testBackToBack();
    loadFlags(4'b0100);
    // Passes on old Z=1, clears Z for the next instruction
    issue(4'h0, 1, 1, 4'b0000, "R11 first", 1, 0);
    issue(4'h0, 1, 0, 4'b0100, "R11 second", 0, 0);
    idle();
    check("R11 flags", flagsOut, 4'b0000);
    issue(4'h1, 1, 1, 4'b0110, "R11 ne", 1, 0);
    issue(4'h2, 1, 0, 4'b0000, "R11 cs", 1, 0);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    testAllPredicates();
    testInvalid();
    testSquashNoUpdate();
    testBackToBack();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule